// File: doc/BRIEF.md
# Segmented Sleep and Clock-Gating Manager

This block is the always-on power manager for a group of peripherals. The peripherals are split into clock segments, and each segment has a fixed number of block slots. Firmware programs a sleep-enable bit and a reset-on-sleep bit for every block through a small register write port. Each block drives one clock-request line back to the manager. The manager closes a segment's clock gate once every request in that segment has dropped.

The manager also tracks system sleep. Firmware picks one of four system sleep states ahead of time. The system-sleep output rises only when three conditions hold together: every block is commanded to sleep, every synchronized clock request is low, and the processor reports that it has executed its sleep instruction. The state selected at that moment is latched onto the mode output.

A wake input briefly forces every sleep-enable output low so that blocks can answer the event. The programmed values then return. The same wake input, or any clock request that rises, ends system sleep.

Top module: `pm_sleep_ctrl`

## Requirements
- R1: After reset, all sleep-enable and reset-on-sleep outputs are 0, every segment gate enable is 0, the system-sleep output is 0, and the mode output is 00.
- R2: A write with address 0 loads the sleep-enable register, and address 1 loads the reset-on-sleep register. Each value appears on its outputs after the write's clock edge. A write to address 3 changes no output.
- R3: Every clock-request input passes through two flip-flops in the manager clock. A change on a request input reaches the gate enables after exactly two clock edges.
- R4: Block b belongs to segment b / BLK_PER_SEG. A segment's gate enable is high exactly when at least one synchronized request in that segment is high, or a wake clear is in progress.
- R5: A wake input sampled high at a clock edge forces every sleep-enable output to 0 for exactly two cycles and opens every segment gate for the same two cycles. After that, the outputs return to the programmed register value. A new wake inside the window restarts the two cycles.
- R6: The system-sleep output rises at the edge that follows a cycle in which all of these hold: every sleep-enable register bit is 1, every synchronized request is 0, the processor-sleep input is 1, no wake clear is active, and the wake input is 0.
- R7: The mode register is written at address 2 from data bits [1:0]. Code 00, 01 and 10 select heavy sleep 1, 2 and 3, and code 11 selects deepest sleep. The mode output takes the register value when system sleep is entered, and it holds that value while asleep even if the register is rewritten.
- R8: The system-sleep output falls at the edge after the wake input is high, or after any synchronized request is high. Clearing takes priority over entry.
- R9: If any single entry condition is missing, the system-sleep output stays 0. This covers one sleep-enable bit at 0, one synchronized request at 1, and the processor-sleep input at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on manager clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 sleep-enable, 1 reset-on-sleep, 2 sleep mode |
| wr_data | input | NSEG*BLK_PER_SEG | Write data |
| clk_req_i | input | NSEG*BLK_PER_SEG | Per-block clock requests, asynchronous |
| cpu_sleep_i | input | 1 | Processor has executed its sleep instruction |
| wake_i | input | 1 | Wake event, synchronous single-cycle or level |
| slp_en_o | output | NSEG*BLK_PER_SEG | Per-block sleep command, grouped by segment |
| rst_on_slp_o | output | NSEG*BLK_PER_SEG | Per-block reset-on-sleep bit |
| seg_clk_en_o | output | NSEG | Clock gate enable per segment |
| sys_sleep_o | output | 1 | System sleep entered |
| sys_mode_o | output | 2 | Sleep state latched at entry |

## Verification
The checker watches several properties on every cycle. It confirms that sleep enables stay low while a wake clear runs and that a wake keeps the clear active for two cycles. It confirms that closed gates match quiet synchronized requests, that system sleep rises only after a cycle meeting all entry conditions, that wake or a request drops it, and that the latched mode does not move while asleep. Some behaviours can only be shown by the bench's scenarios: the exact two-edge request latency, the segment a given block maps to, the ignored address, and a mode rewrite during sleep. For these, the bench compares every output each cycle against its own model under random traffic, and it runs directed cases as well.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    SLP_HEAVY1  = 2'b00,
    SLP_HEAVY2  = 2'b01,
    SLP_HEAVY3  = 2'b10,
    SLP_DEEPEST = 2'b11
  } sys_mode_e;

  localparam logic [1:0] ADDR_SLPEN = 2'd0;
  localparam logic [1:0] ADDR_RSTEN = 2'd1;
  localparam logic [1:0] ADDR_MODE  = 2'd2;

  // all conditions for entering system sleep
  function automatic logic entry_ok(input logic all_cmd, input logic any_req,
                                    input logic cpu_slp, input logic wake_busy);
    return all_cmd & ~any_req & cpu_slp & ~wake_busy;
  endfunction

  // sleep command seen by a block: forced low during a wake clear
  function automatic logic gated_cmd(input logic prog, input logic wake_busy);
    return prog & ~wake_busy;
  endfunction
endpackage

// File: rtl/pm_req_sync.sv
module pm_req_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_async,
  output logic [W-1:0] req_sync
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic s1_q, s2_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1_q <= 1'b0;
          s2_q <= 1'b0;
        end else begin
          s1_q <= req_async[i];
          s2_q <= s1_q;
        end
      end
      assign req_sync[i] = s2_q;
    end
  endgenerate
endmodule

// File: rtl/pm_wake_pulse.sv
module pm_wake_pulse #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_i,
  output logic active
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (wake_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/pm_regs.sv
module pm_regs #(
  parameter int NBLK = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [NBLK-1:0] wr_data,
  output logic [NBLK-1:0] slp_reg,
  output logic [NBLK-1:0] rst_reg,
  output logic [1:0]      mode_reg
);
  import pm_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_reg  <= '0;
      rst_reg  <= '0;
      mode_reg <= SLP_HEAVY1;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_SLPEN: slp_reg  <= wr_data;
        ADDR_RSTEN: rst_reg  <= wr_data;
        ADDR_MODE:  mode_reg <= wr_data[1:0];
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/pm_seg_gate.sv
module pm_seg_gate #(
  parameter int NSEG        = 2,
  parameter int BLK_PER_SEG = 4
) (
  input  logic [NSEG*BLK_PER_SEG-1:0] req_sync,
  input  logic                        force_open,
  output logic [NSEG-1:0]             seg_en
);
  genvar s;
  generate
    for (s = 0; s < NSEG; s++) begin : g_seg
      assign seg_en[s] = (|req_sync[s*BLK_PER_SEG +: BLK_PER_SEG]) | force_open;
    end
  endgenerate
endmodule

// File: rtl/pm_sleep_ctrl.sv
module pm_sleep_ctrl #(
  parameter int NSEG        = 2,
  parameter int BLK_PER_SEG = 4,
  parameter int WAKE_HOLD   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_addr,
  input  logic [NSEG*BLK_PER_SEG-1:0] wr_data,
  input  logic [NSEG*BLK_PER_SEG-1:0] clk_req_i,
  input  logic                        cpu_sleep_i,
  input  logic                        wake_i,
  output logic [NSEG*BLK_PER_SEG-1:0] slp_en_o,
  output logic [NSEG*BLK_PER_SEG-1:0] rst_on_slp_o,
  output logic [NSEG-1:0]             seg_clk_en_o,
  output logic                        sys_sleep_o,
  output logic [1:0]                  sys_mode_o
);
  import pm_pkg::*;

  localparam int NBLK = NSEG * BLK_PER_SEG;

  // named internal events, visible to the checker
  logic [NBLK-1:0] slp_reg;
  logic [NBLK-1:0] rst_reg;
  logic [1:0]      mode_reg;
  logic [NBLK-1:0] req_sync;
  logic            wake_active;
  logic            any_req;
  logic            all_cmd;
  logic            sleep_set;
  logic            sleep_clr;

  pm_regs #(.NBLK(NBLK)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .slp_reg  (slp_reg),
    .rst_reg  (rst_reg),
    .mode_reg (mode_reg)
  );

  pm_req_sync #(.W(NBLK)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_async (clk_req_i),
    .req_sync  (req_sync)
  );

  pm_wake_pulse #(.HOLD(WAKE_HOLD)) u_wake (
    .clk    (clk),
    .rst_n  (rst_n),
    .wake_i (wake_i),
    .active (wake_active)
  );

  pm_seg_gate #(.NSEG(NSEG), .BLK_PER_SEG(BLK_PER_SEG)) u_gate (
    .req_sync   (req_sync),
    .force_open (wake_active),
    .seg_en     (seg_clk_en_o)
  );

  genvar b;
  generate
    for (b = 0; b < NBLK; b++) begin : g_cmd
      assign slp_en_o[b] = gated_cmd(slp_reg[b], wake_active);
    end
  endgenerate

  assign rst_on_slp_o = rst_reg;
  assign any_req      = |req_sync;
  assign all_cmd      = &slp_reg;
  assign sleep_set    = entry_ok(all_cmd, any_req, cpu_sleep_i, wake_active | wake_i);
  assign sleep_clr    = wake_i | any_req;

  logic       sys_q;
  logic [1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q  <= 1'b0;
      mode_q <= SLP_HEAVY1;
    end else if (sleep_clr) begin
      sys_q  <= 1'b0;
    end else if (sleep_set && !sys_q) begin
      sys_q  <= 1'b1;
      mode_q <= mode_reg;
    end
  end

  assign sys_sleep_o = sys_q;
  assign sys_mode_o  = mode_q;
endmodule

// File: rtl/pm_sleep_ctrl_chk.sv
module pm_sleep_ctrl_chk #(
  parameter int NBLK = 8,
  parameter int NSEG = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wake_i,
  input logic            cpu_sleep_i,
  input logic            wake_active,
  input logic [NBLK-1:0] req_sync,
  input logic [NBLK-1:0] slp_en_o,
  input logic [NSEG-1:0] seg_clk_en_o,
  input logic            sys_sleep_o,
  input logic [1:0]      sys_mode_o
);
  // R5
  wake_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_active |-> (slp_en_o == '0));

  // R5
  wake_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |=> wake_active ##1 wake_active);

  // R4
  gates_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sync == '0 && !wake_active) |-> (seg_clk_en_o == '0));

  // R6
  entry_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_sleep_o) |-> $past(slp_en_o == '1 && req_sync == '0 && cpu_sleep_i && !wake_i));

  // R8
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_i || req_sync != '0) |=> !sys_sleep_o);

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_sleep_o && $past(sys_sleep_o)) |-> $stable(sys_mode_o));
endmodule

bind pm_sleep_ctrl pm_sleep_ctrl_chk #(.NBLK(NSEG*BLK_PER_SEG), .NSEG(NSEG)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wake_i       (wake_i),
  .cpu_sleep_i  (cpu_sleep_i),
  .wake_active  (wake_active),
  .req_sync     (req_sync),
  .slp_en_o     (slp_en_o),
  .seg_clk_en_o (seg_clk_en_o),
  .sys_sleep_o  (sys_sleep_o),
  .sys_mode_o   (sys_mode_o)
);

// File: tb/test_pm_sleep_ctrl.sv
`timescale 1ns/1ps
module test_pm_sleep_ctrl;
  localparam int NSEG = 2;
  localparam int BPS  = 4;
  localparam int NB   = NSEG * BPS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [NB-1:0] wr_data = '0;
  logic [NB-1:0] clk_req_i = '0;
  logic          cpu_sleep_i = 1'b0;
  logic          wake_i = 1'b0;
  logic [NB-1:0] slp_en_o, rst_on_slp_o;
  logic [NSEG-1:0] seg_clk_en_o;
  logic          sys_sleep_o;
  logic [1:0]    sys_mode_o;

  always #2 clk = ~clk;

  pm_sleep_ctrl #(.NSEG(NSEG), .BLK_PER_SEG(BPS), .WAKE_HOLD(2)) i_pm_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_req_i(clk_req_i), .cpu_sleep_i(cpu_sleep_i), .wake_i(wake_i),
    .slp_en_o(slp_en_o), .rst_on_slp_o(rst_on_slp_o), .seg_clk_en_o(seg_clk_en_o),
    .sys_sleep_o(sys_sleep_o), .sys_mode_o(sys_mode_o));

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  logic [NB-1:0] m_s1 = '0, m_s2 = '0, m_slp = '0, m_rst = '0;
  logic [1:0]    m_mode = '0, m_smode = '0;
  logic          m_sys = 1'b0;
  int            m_cnt = 0;

  function automatic logic [NSEG-1:0] exp_seg(input logic [NB-1:0] r, input logic open);
    logic [NSEG-1:0] e;
    for (int b = 0; b < NB; b++) if (r[b]) e[b / BPS] = 1'b1;
    for (int s = 0; s < NSEG; s++) if (open) e[s] = 1'b1;
    return e;
  endfunction

  function automatic logic [NSEG-1:0] seg_of(input logic [NB-1:0] r, input logic open);
    logic [NSEG-1:0] e = '0;
    e = e | exp_seg_core(r);
    if (open) e = '1;
    return e;
  endfunction

  function automatic logic [NSEG-1:0] exp_seg_core(input logic [NB-1:0] r);
    logic [NSEG-1:0] e = '0;
    for (int b = 0; b < NB; b++) if (r[b]) e[b / BPS] = 1'b1;
    return e;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic clr, set;
    clr = wake_i | (|m_s2);
    set = (&m_slp) & ~(|m_s2) & cpu_sleep_i & (m_cnt == 0) & ~wake_i;
    if (clr) m_sys = 1'b0;
    else if (set && !m_sys) begin m_sys = 1'b1; m_smode = m_mode; end
    if (wake_i) m_cnt = 2; else if (m_cnt > 0) m_cnt--;
    m_s2 = m_s1;
    m_s1 = clk_req_i;
    if (wr_en) begin
      if (wr_addr == 2'd0) m_slp = wr_data;
      else if (wr_addr == 2'd1) m_rst = wr_data;
      else if (wr_addr == 2'd2) m_mode = wr_data[1:0];
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R2 R5 slp_en", 32'(slp_en_o), 32'(m_cnt != 0 ? '0 : m_slp));
    check("R2 rst_on_slp", 32'(rst_on_slp_o), 32'(m_rst));
    check("R3 R4 seg_en", 32'(seg_clk_en_o), 32'(seg_of(m_s2, m_cnt != 0)));
    check("R6 R8 R9 sys_sleep", 32'(sys_sleep_o), 32'(m_sys));
    check("R7 sys_mode", 32'(sys_mode_o), 32'(m_smode));
  endtask

  task automatic wr(input logic [1:0] a, input logic [NB-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  logic done = 1'b0;

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 slp_en", 32'(slp_en_o), 0);
    check("R1 rst_on", 32'(rst_on_slp_o), 0);
    check("R1 seg_en", 32'(seg_clk_en_o), 0);
    check("R1 sys", 32'(sys_sleep_o), 0);
    check("R1 mode", 32'(sys_mode_o), 0);
    rst_n = 1'b1;
    cyc();

    // R2 writes, ignored address
    wr(2'd0, 8'hA5);
    check("R2 slp write", 32'(slp_en_o), 32'h A5);
    wr(2'd1, 8'h3C);
    check("R2 rst write", 32'(rst_on_slp_o), 32'h3C);
    wr(2'd3, 8'h00);
    check("R2 addr3 slp", 32'(slp_en_o), 32'hA5);
    check("R2 addr3 rst", 32'(rst_on_slp_o), 32'h3C);

    // R3 / R4: block 5 sits in segment 1
    clk_req_i = 8'h20;
    cyc();
    check("R3 one edge", 32'(seg_clk_en_o), 0);
    cyc();
    check("R3 R4 two edges", 32'(seg_clk_en_o), 32'b10);
    clk_req_i = 8'h00;
    cyc(); cyc();
    check("R4 closed", 32'(seg_clk_en_o), 0);

    // R5 wake clear
    wake_i = 1'b1;
    cyc();
    wake_i = 1'b0;
    check("R5 wake c1 slp", 32'(slp_en_o), 0);
    check("R5 wake c1 seg", 32'(seg_clk_en_o), 32'b11);
    cyc();
    check("R5 wake c2 slp", 32'(slp_en_o), 0);
    cyc();
    check("R5 restore", 32'(slp_en_o), 32'hA5);

    // R9 one block not commanded
    wr(2'd2, 8'h03);
    wr(2'd0, 8'hFE);
    cpu_sleep_i = 1'b1;
    cyc(); cyc();
    check("R9 missing cmd", 32'(sys_sleep_o), 0);
    cpu_sleep_i = 1'b0;
    wr(2'd0, 8'hFF);
    cyc();
    check("R9 no cpu", 32'(sys_sleep_o), 0);

    // R6 / R7 entry
    cpu_sleep_i = 1'b1;
    cyc();
    check("R6 entry", 32'(sys_sleep_o), 1);
    check("R7 deepest", 32'(sys_mode_o), 32'd3);
    wr(2'd2, 8'h01);
    cyc();
    check("R7 held", 32'(sys_mode_o), 32'd3);

    // R8 exit on request
    clk_req_i = 8'h01;
    cyc(); cyc();
    check("R8 still asleep", 32'(sys_sleep_o), 1);
    cyc();
    check("R8 exit req", 32'(sys_sleep_o), 0);
    clk_req_i = 8'h00;
    cyc(); cyc(); cyc();
    check("R6 reentry", 32'(sys_sleep_o), 1);
    check("R7 heavy2", 32'(sys_mode_o), 32'd1);
    wake_i = 1'b1;
    cyc();
    wake_i = 1'b0;
    check("R8 exit wake", 32'(sys_sleep_o), 0);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      wr_en = ($urandom % 6) == 0;
      wr_addr = 2'($urandom);
      wr_data = ($urandom % 2) ? 8'hFF : 8'($urandom);
      clk_req_i = (($urandom % 12) == 0) ? 8'(1 << ($urandom % NB)) : 8'h00;
      cpu_sleep_i = ($urandom % 3) != 0;
      wake_i = ($urandom % 40) == 0;
      cyc();
    end
    wr_en = 1'b0; wake_i = 1'b0; clk_req_i = '0;
    cyc();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule